// File: doc/BRIEF.md
# Six-Port Configurable GPIO Bank

This block holds the general-purpose I/O registers that sit behind three logical devices of a configuration controller. Six ports of eight pins each are grouped two to a logical device. Each port has three host-visible registers: a direction register, a data register and an inversion register. The controller presents a logical device number, a register index and write data. The block decodes these and returns read data combinationally for the addressed register. A write is committed on the clock edge.

Several inputs from the controller's global register space decide which pins may actually drive:
- a per-port enable;
- a per-port drive-mode bit that selects push-pull or open drain;
- a two-bit function select for the first port's pins;
- a flag that hands two pins of the second port to an I2C function.

The sixth port has only five pins. Input pins are resynchronised through two flops before they reach the readback path. The inversion registers are only stored for the host to apply in software. They never change a pin.

Top module: `gpio_bank`

## Requirements
- R1: After reset every implemented direction bit reads 1 (input), every data and inversion bit holds 0, and no pin output enable is asserted.
- R2: Within each logical device, the lower port of the pair uses index 0xE0 for direction, 0xE1 for data and 0xE2 for inversion. The upper port of the pair uses 0xE4, 0xE5 and 0xE6. Ports 1-2 sit at device 0x09, ports 3-4 at device 0x07 and ports 5-6 at device 0x08. A write to any other device or index changes no register. A read of an unmapped index returns 0.
- R3: A direction bit of 1 makes its pin an input, which never drives. A direction bit of 0 makes it an output.
- R4: When a port's drive-mode bit is 1 (push-pull), each driving output pin has its output enable set and its output value equal to the stored data bit.
- R5: When a port's drive-mode bit is 0 (open drain), a driving output pin with data 0 is pulled low (enable 1, value 0). A driving output pin with data 1 is released (enable 0). The output value is always 0.
- R6: When a port's enable bit is 0, all of its pins are tri-stated. Its registers stay readable and writable.
- R7: Port 1 pins can drive only while the function select equals 2. The other codes are 0 = IR off, 1 = IR and 3 = second UART.
- R8: Port 6 has pins 0-4 only. Its bits 7:5 read 0 in all three registers and never assert an output enable.
- R9: While the I2C claim input is 1, pins 5 and 6 of port 2 never assert an output enable.
- R10: A data-register read returns the synchronised pin level for input bits and the stored value for output bits. A pin change first appears in the readback after the second rising clock edge.
- R11: The inversion register is read/write storage only and has no effect on pin values or enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the addressed register |
| cfg_dev | input | 8 | Logical device number |
| cfg_idx | input | 8 | Register index within the device |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the addressed register (combinational) |
| port_en | input | 6 | Per-port enable, bit p for port p+1 |
| drv_pp | input | 6 | Per-port drive mode, 1 = push-pull, 0 = open drain |
| p1_fsel | input | 2 | Port 1 pin function select |
| i2c_claim | input | 1 | Port 2 pins 5 and 6 taken by I2C |
| pin_in | input | 48 | Pin levels, bit 8*p+b for port p+1 pin b |
| pin_out | output | 48 | Pin output values |
| pin_oe | output | 48 | Pin output enables |

## Verification
The hardest situation to reach is the two-cycle window of the input synchroniser. From the ports it looks like a data register that ignores the pins for exactly one extra clock. The stimulus changes the pin level just after a clock edge and reads the data register three cycles in a row. It expects the old value twice and the new value on the third read. A second hard case is a port whose bits are split between input and output, where the readback must merge pin levels with stored bits. Direction is therefore written to a mixed pattern before the pins are changed.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int          W         = 8,
  parameter int          LAST_PINS = 5,
  parameter logic [7:0]  DEV_P12   = 8'h09,
  parameter logic [7:0]  DEV_P34   = 8'h07,
  parameter logic [7:0]  DEV_P56   = 8'h08,
  parameter logic [1:0]  FSEL_GPIO = 2'd2,
  parameter logic [7:0]  I2C_MASK  = 8'h60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_wr,
  input  logic [7:0]   cfg_dev,
  input  logic [7:0]   cfg_idx,
  input  logic [7:0]   cfg_wdata,
  output logic [7:0]   cfg_rdata,
  input  logic [5:0]   port_en,
  input  logic [5:0]   drv_pp,
  input  logic [1:0]   p1_fsel,
  input  logic         i2c_claim,
  input  logic [47:0]  pin_in,
  output logic [47:0]  pin_out,
  output logic [47:0]  pin_oe
);
  localparam int NPORT = 6;
  localparam int WTOT  = NPORT * W;

  logic [WTOT-1:0] sync1, sync2;
  logic [W-1:0]    rd_part [NPORT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [7:0] PDEV  = (p < 2) ? DEV_P12 : (p < 4) ? DEV_P34 : DEV_P56;
    localparam logic [7:0] IDIR  = (p % 2 == 1) ? 8'hE4 : 8'hE0;
    localparam logic [7:0] IDAT  = IDIR + 8'd1;
    localparam logic [7:0] IINV  = IDIR + 8'd2;
    localparam int         PW    = (p == NPORT - 1) ? LAST_PINS : W;
    localparam logic [W-1:0] PMASK = W'((1 << PW) - 1);

    logic [W-1:0] dir_q, dat_q, inv_q, lock, drv, pin_lvl;
    logic         dev_hit;

    assign dev_hit = (cfg_dev == PDEV);
    assign pin_lvl = sync2[p*W +: W];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        dir_q <= PMASK;
        dat_q <= '0;
        inv_q <= '0;
      end else if (cfg_wr && dev_hit) begin
        if (cfg_idx == IDIR) dir_q <= cfg_wdata[W-1:0] & PMASK;
        if (cfg_idx == IDAT) dat_q <= cfg_wdata[W-1:0] & PMASK;
        if (cfg_idx == IINV) inv_q <= cfg_wdata[W-1:0] & PMASK;
      end

    always_comb begin
      rd_part[p] = '0;
      if (dev_hit) begin
        if (cfg_idx == IDIR) rd_part[p] = dir_q;
        if (cfg_idx == IDAT) rd_part[p] = ((dir_q & pin_lvl) | (~dir_q & dat_q)) & PMASK;
        if (cfg_idx == IINV) rd_part[p] = inv_q;
      end
    end

    always_comb begin
      lock = PMASK & {W{port_en[p]}};
      if (p == 0 && p1_fsel != FSEL_GPIO) lock = '0;
      if (p == 1 && i2c_claim)            lock = lock & ~I2C_MASK[W-1:0];
    end

    assign drv = ~dir_q & lock;
    assign pin_oe[p*W +: W]  = drv_pp[p] ? drv : (drv & ~dat_q);
    assign pin_out[p*W +: W] = drv_pp[p] ? (drv & dat_q) : '0;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int p = 0; p < NPORT; p++) cfg_rdata = cfg_rdata | 8'(rd_part[p]);
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [5:0]  port_en,
  input logic [5:0]  drv_pp,
  input logic [1:0]  p1_fsel,
  input logic        i2c_claim,
  input logic [47:0] pin_out,
  input logic [47:0] pin_oe
);
  logic [47:0] en_m, pp_m;
  always_comb
    for (int p = 0; p < 6; p++) begin
      en_m[p*8 +: 8] = {8{port_en[p]}};
      pp_m[p*8 +: 8] = {8{drv_pp[p]}};
    end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_oe == '0);                                      // R1
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pp_m) == '0);                                            // R5
  AST_UNEN_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~en_m) == '0);                                             // R6
  AST_P1_FUNC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_fsel != 2'd2) |-> pin_oe[7:0] == 8'h00);                         // R7
  AST_P6_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[47:45] == 3'b000 && pin_out[47:45] == 3'b000);                // R8
  AST_I2C_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    i2c_claim |-> pin_oe[14:13] == 2'b00);                               // R9
endmodule

bind gpio_bank gpio_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .drv_pp(drv_pp),
  .p1_fsel(p1_fsel), .i2c_claim(i2c_claim), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, cfg_wr = 0, i2c_claim = 0;
  logic [7:0]  cfg_dev = 0, cfg_idx = 0, cfg_wdata = 0, cfg_rdata;
  logic [5:0]  port_en = 6'h3F, drv_pp = 6'h3F;
  logic [1:0]  p1_fsel = 2'd2;
  logic [47:0] pin_in = '0, pin_out, pin_oe;

  gpio_bank u_gpio_bank (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [47:0] val; string tag; } item_t;
  item_t q[$];
  int applied = 0, bad = 0, cycles = 0;
  logic mon_go = 0;

  always @(negedge clk) if (mon_go && q.size() > 0) begin
    item_t it;
    logic [47:0] act;
    it = q.pop_front();
    act = (it.kind == 0) ? {40'd0, cfg_rdata} : (it.kind == 1) ? pin_oe : pin_out;
    applied++;
    if (act !== it.val) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.val);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL R1 watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] d, input logic [7:0] i, input logic [7:0] v);
    cfg_wr = 1; cfg_dev = d; cfg_idx = i; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic chk(input int kind, input logic [7:0] d, input logic [7:0] i,
                     input logic [47:0] exp, input string tag);
    item_t it;
    cfg_dev = d; cfg_idx = i;
    it.kind = kind; it.val = exp; it.tag = tag;
    q.push_back(it);
    mon_go = 1;
    @(posedge clk); #1;
    mon_go = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk(0, 8'h09, 8'hE0, 48'hFF, "R1 port1 dir");
    chk(0, 8'h08, 8'hE4, 48'h1F, "R1 port6 dir");
    chk(0, 8'h09, 8'hE1, 48'h00, "R1 port1 data");
    chk(1, 0, 0, 48'h0, "R1 oe");
    // R2 mapping
    wr(8'h09, 8'hE0, 8'h00);
    wr(8'h09, 8'hE1, 8'hA5);
    chk(0, 8'h09, 8'hE1, 48'hA5, "R2 port1 data");
    wr(8'h07, 8'hE6, 8'h3C);
    chk(0, 8'h07, 8'hE6, 48'h3C, "R2 port4 inv");
    chk(0, 8'h07, 8'hE2, 48'h00, "R2 port3 inv untouched");
    chk(0, 8'h09, 8'hE3, 48'h00, "R2 unmapped idx");
    wr(8'h05, 8'hE4, 8'h00);
    chk(0, 8'h09, 8'hE4, 48'hFF, "R2 foreign dev ignored");
    // R3/R4 push-pull
    chk(1, 0, 0, 48'hFF, "R3 R4 oe");
    chk(2, 0, 0, 48'hA5, "R4 out");
    // R11 inversion no effect
    wr(8'h09, 8'hE2, 8'hFF);
    chk(2, 0, 0, 48'hA5, "R11 out unchanged");
    chk(0, 8'h09, 8'hE2, 48'hFF, "R11 inv readback");
    // R5 open drain
    drv_pp = 6'h3E;
    chk(1, 0, 0, 48'h5A, "R5 od oe");
    chk(2, 0, 0, 48'h00, "R5 od out");
    drv_pp = 6'h3F;
    // R6 port disable
    port_en = 6'h3E;
    chk(1, 0, 0, 48'h0, "R6 oe off");
    wr(8'h09, 8'hE1, 8'h0F);
    chk(0, 8'h09, 8'hE1, 48'h0F, "R6 regs writable");
    port_en = 6'h3F;
    chk(2, 0, 0, 48'h0F, "R6 restored out");
    // R7 function select
    p1_fsel = 2'd3;
    chk(1, 0, 0, 48'h0, "R7 uart fsel");
    p1_fsel = 2'd1;
    chk(1, 0, 0, 48'h0, "R7 ir fsel");
    p1_fsel = 2'd2;
    chk(1, 0, 0, 48'hFF, "R7 gpio fsel");
    // R9 I2C claim
    wr(8'h09, 8'hE4, 8'h00);
    wr(8'h09, 8'hE5, 8'hFF);
    chk(1, 0, 0, 48'hFFFF, "R9 no claim");
    i2c_claim = 1;
    chk(1, 0, 0, 48'h9FFF, "R9 claimed");
    i2c_claim = 0;
    // R8 short port
    wr(8'h08, 8'hE4, 8'h00);
    wr(8'h08, 8'hE5, 8'hFF);
    chk(0, 8'h08, 8'hE5, 48'h1F, "R8 data width");
    wr(8'h08, 8'hE6, 8'hFF);
    chk(0, 8'h08, 8'hE6, 48'h1F, "R8 inv width");
    chk(1, 0, 0, 48'h1F00_0000_FFFF, "R8 oe");
    chk(2, 0, 0, 48'h1F00_0000_FF0F, "R8 out");
    // R10 synchroniser and merge
    pin_in = 48'h0000_00C3_00FF;
    chk(0, 8'h07, 8'hE1, 48'h00, "R10 before edge");
    chk(0, 8'h07, 8'hE1, 48'h00, "R10 one edge");
    chk(0, 8'h07, 8'hE1, 48'hC3, "R10 two edges");
    chk(0, 8'h09, 8'hE1, 48'h0F, "R10 output bits stored");
    wr(8'h07, 8'hE0, 8'hF0);
    wr(8'h07, 8'hE1, 8'h05);
    chk(0, 8'h07, 8'hE1, 48'hC5, "R10 mixed merge");
    chk(1, 0, 0, 48'h1F00_0000_FFFF | 48'h0000_000F_0000, "R3 mixed oe");
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule